// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the word address for a synchronous memory that serves bursts of four beats. A burst starts when either of two active-low address strobes is sampled low on a rising clock edge. The strobe loads the whole base address. The upper bits of the output then stay fixed, and the two low bits act as a beat counter that moves one step on each edge where the active-low advance input is low.

The two low bits follow one of two orders. Linear order adds a running count to the start offset, modulo four. Interleaved order combines the start offset with the running count by bitwise exclusive-OR. The order is a configuration input that is captured while reset is held and kept for the whole session. Bursts are optional: a strobe may be given on every cycle, and each one takes effect at once with no dead cycle.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released with no strobe, word_addr is all zeros.
- R2: A low level on strobe_cpu_n or on strobe_ctl_n at a rising edge loads base_addr. From that edge on, word_addr equals the loaded base_addr.
- R3: When both strobes are low at the same edge, the block loads base_addr once, exactly as it does for a single strobe.
- R4: When both strobes and adv_n are high at an edge, word_addr keeps its value.
- R5: With the captured order low (linear), beat k of a burst has low bits (start + k) mod 4, where start is base_addr[1:0] at load. Start 01 gives 01,10,11,00.
- R6: With the captured order high (interleaved), beat k has low bits start XOR k. Start 10 gives 10,11,00,01 and start 11 gives 11,10,01,00.
- R7: The fourth advance after a load returns the low bits to the start value, and the fifth advance repeats the second beat.
- R8: word_addr bits above bit 1 change only on an edge where a strobe loads.
- R9: When a strobe and a low adv_n occur at the same edge, the load wins. word_addr equals the new base_addr, and the next advance gives beat one of the new burst.
- R10: order_sel is sampled only while rst_n is low. Changing it after reset has no effect on the sequence.
- R11: Strobes given on consecutive cycles each load their own base_addr, with no lost cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset. Clears the counter asynchronously and captures order_sel synchronously |
| strobe_cpu_n | input | 1 | Processor-side address strobe, active low |
| strobe_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Beat advance, active low |
| order_sel | input | 1 | Burst order: 0 selects linear, 1 selects interleaved. Captured during reset |
| base_addr | input | ADDR_W | Address to load. Bits [1:0] are the burst start offset |
| word_addr | output | ADDR_W | Current word address |

## Verification
On every cycle, the assertions check the following: a load shows the strobed address on the next cycle, an idle cycle holds the address, the upper bits move only on loads, an advance always changes the low bits, load takes priority over advance, and a wrap returns to the start offset. Only the bench's scenarios can show the exact beat order for each start offset in both orders, the wrap on the fifth beat, and that a late change of order_sel is ignored. The bench compares these against its own sequence model over directed bursts and a long random stretch.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int BEAT_W = 2;
  localparam int BEATS  = 1 << BEAT_W;

  typedef logic [BEAT_W-1:0] beat_t;

  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_XOR    = 1'b1
  } order_e;

  // linear order: start offset plus running count, wrapping at BEATS
  function automatic beat_t linear_beat(beat_t start, beat_t count);
    return beat_t'(start + count);
  endfunction

  // interleaved order: start offset with running count folded in by XOR
  function automatic beat_t xor_beat(beat_t start, beat_t count);
    return start ^ count;
  endfunction

  function automatic beat_t map_beat(order_e mode, beat_t start, beat_t count);
    return (mode == ORDER_XOR) ? xor_beat(start, count) : linear_beat(start, count);
  endfunction
endpackage

// File: rtl/burst_mode_latch.sv
module burst_mode_latch
  import burst_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   order_sel,
  output order_e mode_q
);
  // configuration is followed only while reset is held, then frozen
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= order_e'(order_sel);
  end
endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl (
  input  logic strobe_cpu_n,
  input  logic strobe_ctl_n,
  input  logic adv_n,
  output logic load_ev,
  output logic step_ev
);
  always_comb begin
    load_ev = !strobe_cpu_n || !strobe_ctl_n;
    // load has priority over advance
    step_ev = !adv_n && !load_ev;
  end
endmodule

// File: rtl/burst_counter.sv
module burst_counter
  import burst_pkg::*;
#(
  parameter int ADDR_W = 18,
  localparam int UPPER_W = ADDR_W - BEAT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_ev,
  input  logic               step_ev,
  input  logic [ADDR_W-1:0]  base_addr,
  output logic [UPPER_W-1:0] upper_q,
  output beat_t              start_q,
  output beat_t              count_q,
  output logic               wrap_ev
);
  localparam beat_t LAST = beat_t'(BEATS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= '0;
      start_q <= '0;
      count_q <= '0;
    end else if (load_ev) begin
      upper_q <= base_addr[ADDR_W-1:BEAT_W];
      start_q <= base_addr[BEAT_W-1:0];
      count_q <= '0;
    end else if (step_ev) begin
      count_q <= count_q + beat_t'(1);
    end
  end

  assign wrap_ev = step_ev && (count_q == LAST);
endmodule

// File: rtl/burst_beat_map.sv
module burst_beat_map
  import burst_pkg::*;
(
  input  order_e mode,
  input  beat_t  start,
  input  beat_t  count,
  output beat_t  beat
);
  always_comb beat = map_beat(mode, start, count);
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_cpu_n,
  input  logic              strobe_ctl_n,
  input  logic              adv_n,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] base_addr,
  output logic [ADDR_W-1:0] word_addr
);
  localparam int UPPER_W = ADDR_W - BEAT_W;

  order_e             mode_q;
  logic               load_ev;
  logic               step_ev;
  logic               wrap_ev;
  logic [UPPER_W-1:0] upper_q;
  beat_t              start_q;
  beat_t              count_q;
  beat_t              beat;

  burst_mode_latch u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .order_sel (order_sel),
    .mode_q    (mode_q)
  );

  burst_ctrl u_ctrl (
    .strobe_cpu_n (strobe_cpu_n),
    .strobe_ctl_n (strobe_ctl_n),
    .adv_n        (adv_n),
    .load_ev      (load_ev),
    .step_ev      (step_ev)
  );

  burst_counter #(.ADDR_W(ADDR_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_ev   (load_ev),
    .step_ev   (step_ev),
    .base_addr (base_addr),
    .upper_q   (upper_q),
    .start_q   (start_q),
    .count_q   (count_q),
    .wrap_ev   (wrap_ev)
  );

  burst_beat_map u_map (
    .mode  (mode_q),
    .start (start_q),
    .count (count_q),
    .beat  (beat)
  );

  assign word_addr = {upper_q, beat};
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk
  import burst_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              strobe_cpu_n,
  input logic              strobe_ctl_n,
  input logic              adv_n,
  input logic [ADDR_W-1:0] base_addr,
  input logic [ADDR_W-1:0] word_addr,
  input logic              load_ev,
  input logic              step_ev,
  input logic              wrap_ev,
  input beat_t             start_q,
  input beat_t             count_q
);
  // R2
  load_shows_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> word_addr == $past(base_addr));

  // R3
  strobe_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_cpu_n || !strobe_ctl_n) |-> load_ev);

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_cpu_n && strobe_ctl_n && adv_n) |=> $stable(word_addr));

  // R8
  upper_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_ev |=> $stable(word_addr[ADDR_W-1:BEAT_W]));

  // R5
  step_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_ev |=> word_addr[BEAT_W-1:0] != $past(word_addr[BEAT_W-1:0]));

  // R9
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ev && !adv_n) |=> count_q == '0);

  // R9
  one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_ev, step_ev}));

  // R7
  wrap_to_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_ev |=> word_addr[BEAT_W-1:0] == $past(start_q));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .strobe_cpu_n (strobe_cpu_n),
  .strobe_ctl_n (strobe_ctl_n),
  .adv_n        (adv_n),
  .base_addr    (base_addr),
  .word_addr    (word_addr),
  .load_ev      (load_ev),
  .step_ev      (step_ev),
  .wrap_ev      (wrap_ev),
  .start_q      (start_q),
  .count_q      (count_q)
);

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
  localparam int ADDR_W = 18;
  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              strobe_cpu_n = 1'b1;
  logic              strobe_ctl_n = 1'b1;
  logic              adv_n = 1'b1;
  logic              order_sel = 1'b0;
  logic [ADDR_W-1:0] base_addr = '0;
  logic [ADDR_W-1:0] word_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state
  logic [ADDR_W-3:0] m_upper;
  int                m_start;
  int                m_beat;
  bit                m_mode;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_gen #(.ADDR_W(ADDR_W)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe_cpu_n (strobe_cpu_n),
    .strobe_ctl_n (strobe_ctl_n),
    .adv_n        (adv_n),
    .order_sel    (order_sel),
    .base_addr    (base_addr),
    .word_addr    (word_addr)
  );

  // linear: walk forward beat by beat, folding back to zero after three
  function automatic int lin_ref(int s, int k);
    int v = s;
    for (int i = 0; i < k; i++) v = (v == 3) ? 0 : v + 1;
    return v;
  endfunction

  // interleaved: each bit of the offset flips where the beat number has a one
  function automatic int ilv_ref(int s, int k);
    int hi = ((s >> 1) & 1) != ((k >> 1) & 1) ? 1 : 0;
    int lo = (s & 1) != (k & 1) ? 1 : 0;
    return hi * 2 + lo;
  endfunction

  function automatic logic [ADDR_W-1:0] expected();
    int low = m_mode ? ilv_ref(m_start, m_beat) : lin_ref(m_start, m_beat);
    return {m_upper, low[1:0]};
  endfunction

  task automatic check(string req, logic [ADDR_W-1:0] got, logic [ADDR_W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic do_reset(bit mode);
    rst_n = 1'b0;
    order_sel = mode;
    strobe_cpu_n = 1'b1; strobe_ctl_n = 1'b1; adv_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1", word_addr, '0);
    rst_n = 1'b1;
    m_upper = '0; m_start = 0; m_beat = 0; m_mode = mode;
    @(posedge clk); #1;
    check("R1", word_addr, '0);
  endtask

  task automatic step(string req, bit a_n, bit b_n, bit v_n, logic [ADDR_W-1:0] base);
    strobe_cpu_n = a_n; strobe_ctl_n = b_n; adv_n = v_n; base_addr = base;
    @(posedge clk);
    if (!a_n || !b_n) begin
      m_upper = base[ADDR_W-1:2];
      m_start = int'(base[1:0]);
      m_beat  = 0;
    end else if (!v_n) begin
      m_beat = (m_beat + 1) % 4;
    end
    #1;
    check(req, word_addr, expected());
    strobe_cpu_n = 1'b1; strobe_ctl_n = 1'b1; adv_n = 1'b1;
  endtask

  task automatic burst(string req, int s);
    logic [ADDR_W-1:0] b = {16'($urandom), 2'(s)};
    step("R2", 1'b0, 1'b1, 1'b1, b);
    for (int i = 0; i < 3; i++) step(req, 1'b1, 1'b1, 1'b0, '0);
    step("R7", 1'b1, 1'b1, 1'b0, '0);
    check("R7", word_addr, b);
    step("R7", 1'b1, 1'b1, 1'b0, '0);
    step("R4", 1'b1, 1'b1, 1'b1, 18'h3ffff);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_upper = '0; m_start = 0; m_beat = 0; m_mode = 0;

    // linear order
    do_reset(1'b0);
    for (int s = 0; s < 4; s++) burst("R5", s);
    step("R2", 1'b1, 1'b0, 1'b1, 18'h2a5c1);
    step("R3", 1'b0, 1'b0, 1'b1, 18'h15a3e);
    step("R5", 1'b1, 1'b1, 1'b0, '0);
    step("R9", 1'b0, 1'b1, 1'b0, 18'h0f0f2);
    step("R9", 1'b1, 1'b1, 1'b0, '0);
    check("R9", word_addr, 18'h0f0f3);
    for (int i = 0; i < 6; i++) step("R11", i[0], !i[0], 1'b0, 18'(i * 4099 + 3));
    // late change of the order input must be ignored
    order_sel = 1'b1;
    step("R10", 1'b0, 1'b1, 1'b1, 18'h00005);
    step("R10", 1'b1, 1'b1, 1'b0, '0);
    check("R10", word_addr, 18'h00006);
    step("R10", 1'b1, 1'b1, 1'b0, '0);
    check("R10", word_addr, 18'h00007);

    // interleaved order
    do_reset(1'b1);
    for (int s = 0; s < 4; s++) burst("R6", s);
    step("R6", 1'b0, 1'b1, 1'b1, 18'h12343);
    step("R6", 1'b1, 1'b1, 1'b0, '0);
    check("R6", word_addr, 18'h12342);
    order_sel = 1'b0;
    step("R10", 1'b1, 1'b1, 1'b0, '0);
    check("R10", word_addr, 18'h12341);

    // random stretch in both orders
    for (int r = 0; r < 2; r++) begin
      do_reset(r[0]);
      for (int i = 0; i < 3000; i++) begin
        int p = $urandom_range(0, 9);
        bit a_n = !(p == 0 || p == 9);
        bit b_n = !(p == 1 || p == 9);
        bit v_n = $urandom_range(0, 2) == 0;
        order_sel = 1'($urandom);
        step(r[0] ? "R6 R8" : "R5 R8", a_n, b_n, v_n, 18'($urandom));
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule